// File: doc/BRIEF.md
# Monitor Load Detection Sequencer

This block decides whether an analog display is attached to the secondary video DAC. It does this by driving a known signal into the DAC outputs and reading back a comparator. A single start pulse runs a fixed sequence:

- save the secondary output-routing word and the secondary DAC control word;
- power the DAC up and gate its outputs;
- wait for the lines to settle, then re-enable the analog path;
- load fixed RGB test levels into a test-signal generator that belongs to the primary DAC, and route them out;
- wait again, then sample the comparator-sense input;
- withdraw the test routing and put both saved words back.

Only after the restore does the block pulse `done_o` and present the result on `present_o`.

The four control words sit in a small register bank. Software, or the surrounding logic, reaches the bank through a simple write port and a combinational read port. Host writes are accepted only while the sequencer is idle. The analog comparator and the DAC are outside the block. The comparator appears as the `sense_i` input, and the four words are brought out as ports.

Top module: `crt_sense_seq`

## Requirements
- R1: After reset the routing word is 0, the secondary control word is 0x00010000 (powered down), the primary control word and test-data word are 0, and `done_o` and `present_o` are 0.
- R2: The register address is 0 for routing, 1 for secondary control, 2 for primary control and 3 for test data. A write while idle takes effect at the clock edge that samples it. `rd_data_o` shows the addressed word combinationally.
- R3: A start is accepted only while idle. Starts and host writes that arrive while a sequence runs (including its done cycle) are ignored.
- R4: Counting the accepting edge as k=0, the secondary control word is saved at k=1, and at k=2 its bit 16 is cleared. At k=3 the routing word is ANDed with 0x0000FEEE.
- R5: At k=5+S the test-data word is loaded with 0x94050140 (value 2 in bits 31:30 and 0x140 in each of bits 29:20, 19:10 and 9:0). At k=6+S bit 12 of the primary control word is set.
- R6: S equals SETTLE_US*CLK_MHZ cycles. Bit 0 of the routing word is set again at k=4+S, and a sequence spans 11+2S edges from acceptance back to idle.
- R7: `sense_i` is sampled at edge k=7+2S, and that value becomes the reported result.
- R8: Bit 12 of the primary control word is cleared at k=8+2S. The saved routing word is restored at k=9+2S and the saved secondary control word at k=10+2S.
- R9: `done_o` is high for exactly the one cycle after edge k=10+2S, and `present_o` takes its new value in that same cycle. `present_o` then holds until the next accepted start, which clears it to 0.
- R10: A host write and a start sampled at the same idle edge both take effect. The word that is saved and later restored is the newly written one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start a detection sequence (accepted when idle) |
| done_o | output | 1 | One-cycle pulse when the sequence has finished |
| present_o | output | 1 | Detection result, 1 = display loading the outputs |
| sense_i | input | 1 | Comparator sense: all signal paths high |
| wr_en_i | input | 1 | Host write strobe |
| wr_addr_i | input | 2 | Host write address |
| wr_data_i | input | 32 | Host write data |
| rd_addr_i | input | 2 | Host read address |
| rd_data_o | output | 32 | Addressed word |
| route_o | output | 32 | Secondary output-routing word |
| sctrl_o | output | 32 | Secondary DAC control word |
| pctrl_o | output | 32 | Primary DAC control word |
| tdata_o | output | 32 | Test-level word |

## Verification
A host write and the start pulse can arrive at the same idle edge. In that case the write must land before the save step reads the bank. The bench provokes this by driving a new routing value in the start cycle of one run. It judges the case by checking that exactly this value reappears on `route_o` after the restore step. The comparator input toggles on most cycles, so a sample taken one cycle early or late shows up as a wrong result.

// File: rtl/crt_sense_pkg.sv
package crt_sense_pkg;

    localparam int WORD_W   = 32;
    localparam int NUM_REGS = 4;
    localparam int ADDR_W   = $clog2(NUM_REGS);

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] raddr_t;

    localparam raddr_t A_ROUTE = 2'd0;
    localparam raddr_t A_SCTRL = 2'd1;
    localparam raddr_t A_PCTRL = 2'd2;
    localparam raddr_t A_TDATA = 2'd3;

    localparam int PWR_DOWN_BIT   = 16;
    localparam int TEST_ROUTE_BIT = 12;
    localparam int ANALOG_EN_BIT  = 0;

    localparam word_t PWR_MASK        = word_t'(1) << PWR_DOWN_BIT;
    localparam word_t ROUTE_TEST_MASK = word_t'(1) << TEST_ROUTE_BIT;
    localparam word_t ANALOG_EN_MASK  = word_t'(1) << ANALOG_EN_BIT;
    localparam word_t GATE_MASK       = 32'h0000_FEEE;
    localparam word_t SCTRL_RST       = PWR_MASK;

    localparam logic [1:0] TEST_MODE  = 2'd2;
    localparam logic [9:0] TEST_LEVEL = 10'h140;

    typedef enum logic [1:0] {OP_NONE, OP_AND, OP_OR, OP_LOAD} opkind_t;

    typedef struct packed {
        opkind_t kind;
        raddr_t  addr;
        word_t   val;
    } regop_t;

    typedef enum logic [3:0] {
        ST_IDLE, ST_SAVE, ST_PWR, ST_GATE, ST_WAIT1, ST_REEN, ST_TEST,
        ST_ROUTE, ST_WAIT2, ST_SENSE, ST_UNROUTE, ST_REST_RT, ST_REST_CT,
        ST_DONE
    } seq_state_t;

    function automatic word_t test_word();
        return {TEST_MODE, TEST_LEVEL, TEST_LEVEL, TEST_LEVEL};
    endfunction

    function automatic word_t reset_value(int idx);
        return (idx == int'(A_SCTRL)) ? SCTRL_RST : '0;
    endfunction

    function automatic word_t apply_op(word_t cur, regop_t op);
        case (op.kind)
            OP_AND:  return cur & op.val;
            OP_OR:   return cur | op.val;
            OP_LOAD: return op.val;
            default: return cur;
        endcase
    endfunction

endpackage

// File: rtl/crt_sense_regbank.sv
module crt_sense_regbank
    import crt_sense_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   host_we,
    input  raddr_t host_addr,
    input  word_t  host_data,
    input  regop_t op,
    input  raddr_t rd_addr,
    output word_t  rd_data,
    output word_t  route,
    output word_t  sctrl,
    output word_t  pctrl,
    output word_t  tdata
);

    word_t regs [NUM_REGS];

    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rst) begin
                regs[i] <= reset_value(i);
            end else if (host_we && host_addr == raddr_t'(i)) begin
                regs[i] <= host_data;
            end else if (op.kind != OP_NONE && op.addr == raddr_t'(i)) begin
                regs[i] <= apply_op(regs[i], op);
            end
        end
    end

    assign rd_data = regs[rd_addr];
    assign route   = regs[A_ROUTE];
    assign sctrl   = regs[A_SCTRL];
    assign pctrl   = regs[A_PCTRL];
    assign tdata   = regs[A_TDATA];

endmodule

// File: rtl/crt_sense_timer.sv
module crt_sense_timer #(
    parameter int LIMIT = 125000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);

    localparam int CNT_W = $clog2(LIMIT + 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = run && (cnt == CNT_W'(LIMIT - 1));

endmodule

// File: rtl/crt_sense_ctrl.sv
module crt_sense_ctrl
    import crt_sense_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  logic   sense,
    input  logic   wait_done,
    input  word_t  cur_route,
    input  word_t  cur_sctrl,
    output regop_t op,
    output logic   wait_run,
    output logic   idle,
    output logic   done,
    output logic   present
);

    seq_state_t state, nxt;
    word_t      saved_rt, saved_ct;
    logic       sensed;

    always_comb begin
        nxt      = state;
        op       = '{kind: OP_NONE, addr: A_ROUTE, val: '0};
        wait_run = 1'b0;
        case (state)
            ST_IDLE:    if (start) nxt = ST_SAVE;
            ST_SAVE:    nxt = ST_PWR;
            ST_PWR: begin
                op  = '{kind: OP_AND, addr: A_SCTRL, val: ~PWR_MASK};
                nxt = ST_GATE;
            end
            ST_GATE: begin
                op  = '{kind: OP_AND, addr: A_ROUTE, val: GATE_MASK};
                nxt = ST_WAIT1;
            end
            ST_WAIT1: begin
                wait_run = 1'b1;
                if (wait_done) nxt = ST_REEN;
            end
            ST_REEN: begin
                op  = '{kind: OP_OR, addr: A_ROUTE, val: ANALOG_EN_MASK};
                nxt = ST_TEST;
            end
            ST_TEST: begin
                op  = '{kind: OP_LOAD, addr: A_TDATA, val: test_word()};
                nxt = ST_ROUTE;
            end
            ST_ROUTE: begin
                op  = '{kind: OP_OR, addr: A_PCTRL, val: ROUTE_TEST_MASK};
                nxt = ST_WAIT2;
            end
            ST_WAIT2: begin
                wait_run = 1'b1;
                if (wait_done) nxt = ST_SENSE;
            end
            ST_SENSE:   nxt = ST_UNROUTE;
            ST_UNROUTE: begin
                op  = '{kind: OP_AND, addr: A_PCTRL, val: ~ROUTE_TEST_MASK};
                nxt = ST_REST_RT;
            end
            ST_REST_RT: begin
                op  = '{kind: OP_LOAD, addr: A_ROUTE, val: saved_rt};
                nxt = ST_REST_CT;
            end
            ST_REST_CT: begin
                op  = '{kind: OP_LOAD, addr: A_SCTRL, val: saved_ct};
                nxt = ST_DONE;
            end
            default:    nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            saved_rt <= '0;
            saved_ct <= '0;
            sensed   <= 1'b0;
            present  <= 1'b0;
        end else begin
            state <= nxt;
            if (state == ST_SAVE) begin
                saved_rt <= cur_route;
                saved_ct <= cur_sctrl;
            end
            if (state == ST_SENSE) sensed <= sense;
            if (state == ST_IDLE && start) present <= 1'b0;
            if (state == ST_REST_CT) present <= sensed;
        end
    end

    assign idle = (state == ST_IDLE);
    assign done = (state == ST_DONE);

endmodule

// File: rtl/crt_sense_seq.sv
module crt_sense_seq
    import crt_sense_pkg::*;
#(
    parameter int SETTLE_US = 1000,
    parameter int CLK_MHZ   = 125
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start_i,
    output logic        done_o,
    output logic        present_o,
    input  logic        sense_i,
    input  logic        wr_en_i,
    input  logic [1:0]  wr_addr_i,
    input  logic [31:0] wr_data_i,
    input  logic [1:0]  rd_addr_i,
    output logic [31:0] rd_data_o,
    output logic [31:0] route_o,
    output logic [31:0] sctrl_o,
    output logic [31:0] pctrl_o,
    output logic [31:0] tdata_o
);

    localparam int SETTLE_CYC = (SETTLE_US * CLK_MHZ < 1) ? 1 : SETTLE_US * CLK_MHZ;

    regop_t seq_op;
    logic   seq_idle;
    logic   wait_run;
    logic   wait_done;

    crt_sense_regbank u_bank (
        .clk       (clk),
        .rst       (rst),
        .host_we   (wr_en_i && seq_idle),
        .host_addr (wr_addr_i),
        .host_data (wr_data_i),
        .op        (seq_op),
        .rd_addr   (rd_addr_i),
        .rd_data   (rd_data_o),
        .route     (route_o),
        .sctrl     (sctrl_o),
        .pctrl     (pctrl_o),
        .tdata     (tdata_o)
    );

    crt_sense_timer #(.LIMIT(SETTLE_CYC)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (wait_run),
        .expired (wait_done)
    );

    crt_sense_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start_i),
        .sense     (sense_i),
        .wait_done (wait_done),
        .cur_route (route_o),
        .cur_sctrl (sctrl_o),
        .op        (seq_op),
        .wait_run  (wait_run),
        .idle      (seq_idle),
        .done      (done_o),
        .present   (present_o)
    );

endmodule

// File: rtl/crt_sense_chk.sv
module crt_sense_chk
    import crt_sense_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        start_i,
    input logic        done_o,
    input logic        present_o,
    input logic        idle,
    input logic [31:0] pctrl_o,
    input logic [31:0] tdata_o
);

    assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    assert_present_rise_with_done_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(present_o) |-> done_o);

    assert_present_clear_on_start_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(present_o) |-> $past(start_i && idle));

    assert_route_after_levels_R5: assert property (@(posedge clk) disable iff (rst)
        (!idle && $rose(pctrl_o[TEST_ROUTE_BIT])) |-> tdata_o == test_word());

    assert_unrouted_at_done_R8: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !pctrl_o[TEST_ROUTE_BIT]);

endmodule

bind crt_sense_seq crt_sense_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .done_o    (done_o),
    .present_o (present_o),
    .idle      (seq_idle),
    .pctrl_o   (pctrl_o),
    .tdata_o   (tdata_o)
);

// File: tb/test_crt_sense_seq.sv
`timescale 1ns/1ps
module test_crt_sense_seq;

    localparam int S_US  = 1;
    localparam int C_MHZ = 4;
    localparam int S     = S_US * C_MHZ;
    localparam int SPAN  = 11 + 2 * S;
    localparam logic [31:0] TWORD = 32'h9405_0140;

    logic        clk = 0;
    logic        rst = 1;
    logic        start_i = 0;
    logic        done_o, present_o;
    logic        sense_i = 0;
    logic        wr_en_i = 0;
    logic [1:0]  wr_addr_i = 0;
    logic [31:0] wr_data_i = 0;
    logic [1:0]  rd_addr_i = 0;
    logic [31:0] rd_data_o, route_o, sctrl_o, pctrl_o, tdata_o;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int sense_mode = 0;   // 0 pattern, 1 high, 2 low

    always #4 clk = ~clk;

    crt_sense_seq #(.SETTLE_US(S_US), .CLK_MHZ(C_MHZ)) i_crt_sense_seq (
        .clk(clk), .rst(rst), .start_i(start_i), .done_o(done_o),
        .present_o(present_o), .sense_i(sense_i), .wr_en_i(wr_en_i),
        .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i),
        .rd_data_o(rd_data_o), .route_o(route_o), .sctrl_o(sctrl_o),
        .pctrl_o(pctrl_o), .tdata_o(tdata_o)
    );

    // behavioural reference: four words, a busy flag and an edge counter
    logic [31:0] m_reg [4];
    logic [31:0] sv_rt, sv_ct;
    bit m_busy, m_sensed, m_present, m_done;
    int k;

    always @(posedge clk) begin
        if (rst) begin
            m_reg[0] = 0; m_reg[1] = 32'h0001_0000; m_reg[2] = 0; m_reg[3] = 0;
            m_busy = 0; m_present = 0; m_done = 0; k = 0;
        end else if (!m_busy) begin
            if (wr_en_i) m_reg[wr_addr_i] = wr_data_i;
            if (start_i) begin m_busy = 1; k = 0; m_present = 0; end
        end else begin
            k++;
            if (k == 1) begin sv_rt = m_reg[0]; sv_ct = m_reg[1]; end
            if (k == 2) m_reg[1] = m_reg[1] & ~32'h0001_0000;
            if (k == 3) m_reg[0] = m_reg[0] & 32'h0000_FEEE;
            if (k == 4 + S) m_reg[0] = m_reg[0] | 32'h1;
            if (k == 5 + S) m_reg[3] = TWORD;
            if (k == 6 + S) m_reg[2] = m_reg[2] | 32'h1000;
            if (k == 7 + 2*S) m_sensed = sense_i;
            if (k == 8 + 2*S) m_reg[2] = m_reg[2] & ~32'h1000;
            if (k == 9 + 2*S) m_reg[0] = sv_rt;
            if (k == 10 + 2*S) begin m_reg[1] = sv_ct; m_present = m_sensed; m_done = 1; end
            if (k == 11 + 2*S) begin m_done = 0; m_busy = 0; end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // per-cycle comparison, then drive the free-running inputs
    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            chk(route_o === m_reg[0], "R4 route", route_o, m_reg[0]);
            chk(sctrl_o === m_reg[1], "R4 sctrl", sctrl_o, m_reg[1]);
            chk(pctrl_o === m_reg[2], "R5 pctrl", pctrl_o, m_reg[2]);
            chk(tdata_o === m_reg[3], "R5 tdata", tdata_o, m_reg[3]);
            chk(done_o === m_done, "R9 done", 32'(done_o), 32'(m_done));
            chk(present_o === m_present, "R7 present", 32'(present_o), 32'(m_present));
            chk(rd_data_o === m_reg[rd_addr_i], "R2 read", rd_data_o, m_reg[rd_addr_i]);
        end
        rd_addr_i <= 2'(cyc);
        case (sense_mode)
            1: sense_i <= 1'b1;
            2: sense_i <= 1'b0;
            default: sense_i <= cyc[0] ^ cyc[2];
        endcase
        if (cyc > 20000) begin
            fails++;
            $display("FAIL watchdog R6 actual=%0d expected=%0d", cyc, 20000);
            finish_run();
        end
    end

    task automatic hwrite(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en_i = 1; wr_addr_i = a; wr_data_i = d;
        @(negedge clk);
        wr_en_i = 0;
    endtask

    // start (optionally with a write in the same cycle), return cycles to done
    task automatic run_seq(input bit with_wr, input logic [31:0] wd, input bit poke, output int n);
        @(negedge clk);
        start_i = 1;
        if (with_wr) begin wr_en_i = 1; wr_addr_i = 0; wr_data_i = wd; end
        n = 0;
        do begin
            @(negedge clk);
            n++;
            start_i = 0; wr_en_i = 0;
            if (n == 1) chk(present_o == 0, "R9 cleared on start", 32'(present_o), 0);
            if (poke && n == 5) begin
                start_i = 1; wr_en_i = 1; wr_addr_i = 0; wr_data_i = 32'hDEAD_BEEF;
            end
        end while (!done_o && n < 1000);
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(route_o == 0 && pctrl_o == 0 && tdata_o == 0, "R1 zero words", route_o | pctrl_o | tdata_o, 0);
        chk(sctrl_o == 32'h0001_0000, "R1 sctrl", sctrl_o, 32'h0001_0000);
        chk(!done_o && !present_o, "R1 flags", {done_o, present_o}, 0);

        hwrite(0, 32'h0000_FFFF);
        hwrite(1, 32'h0001_0ABC);
        hwrite(2, 32'h0000_0003);

        sense_mode = 1;
        run_seq(0, 0, 1, n);
        chk(n == SPAN, "R6 span", n, SPAN);
        chk(present_o == 1, "R7 present high", 32'(present_o), 1);
        chk(route_o == 32'h0000_FFFF, "R3 busy write ignored", route_o, 32'h0000_FFFF);
        chk(sctrl_o == 32'h0001_0ABC, "R8 ctrl restored", sctrl_o, 32'h0001_0ABC);
        @(negedge clk);
        chk(present_o == 1, "R9 present holds", 32'(present_o), 1);
        chk(!done_o, "R9 done one cycle", 32'(done_o), 0);

        sense_mode = 2;
        run_seq(0, 0, 0, n);
        chk(present_o == 0, "R7 present low", 32'(present_o), 0);
        chk(pctrl_o == 32'h3, "R8 test route withdrawn", pctrl_o, 32'h3);

        sense_mode = 0;
        run_seq(1, 32'h0000_1234, 0, n);
        chk(route_o == 32'h0000_1234, "R10 same-cycle write restored", route_o, 32'h0000_1234);
        chk(tdata_o == TWORD, "R5 test word", tdata_o, TWORD);
        chk(n == SPAN, "R6 span 2", n, SPAN);

        hwrite(1, 32'h0000_0000);
        run_seq(0, 0, 0, n);
        chk(sctrl_o == 0, "R4 powered ctrl restored", sctrl_o, 0);
        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule